// File: doc/BRIEF.md
# Dual-Mode Serial Baud Generator

This block makes the baud tick for one serial channel. It counts source events and raises a tick every time its reload count runs out. A source event is either every system clock cycle or a rising edge seen on an external clock pin. Each channel has its own instance, separate from the general-purpose timers. The transmit and receive shift logic use the tick as their clock enable.

In asynchronous mode the tick rate is eight times the bit rate, which gives the receiver its oversampling clock. In synchronous mode the tick rate equals the bit rate. A stage after the divider multiplies the divide by eight in that mode, so one divisor value gives the same bit rate in both modes.

No data streams through the block, so it has no valid/ready interface. Every pin is plain control. A divisor write takes effect in the cycle it is sampled, and the block never stalls it.

Top module: `baud_gen`

## Requirements
- R1: While `rst_n` is low, `tick` is 0.
- R2: With the internal source and asynchronous mode (`src_ext`=0, `mode_sync`=0) and divisor D, `tick` pulses every D+1 clock cycles. Each pulse is one cycle wide when D>0. When D=0, `tick` stays high.
- R3: With the internal source and synchronous mode (`mode_sync`=1), `tick` pulses every 8·(D+1) clock cycles.
- R4: With `src_ext`=1, only rising edges of `ext_clk` count, after a two-flop synchroniser. Ticks come every D+1 edges in asynchronous mode and every 8·(D+1) edges in synchronous mode. With `ext_clk` held still, `tick` stays 0.
- R5: When `div_wr` is high at a clock edge, `div_wdata` is loaded and the count restarts. `tick` is 0 in the following cycle. With the internal source, the first new tick appears D+1 cycles after that edge.
- R6: With `src_ext`=0, toggling `ext_clk` does not change the tick period.
- R7: In synchronous mode every tick pulse is exactly one cycle wide.
- R8: An `ext_clk` at half the system frequency (toggling every cycle) is counted edge for edge, giving a tick period of 2·(D+1) cycles in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor reload value D |
| src_ext | input | 1 | Source select: 1 means `ext_clk` rising edges, 0 means the system clock |
| mode_sync | input | 1 | Mode select: 1 means a 1x bit-rate tick, 0 means an 8x oversampling tick |
| ext_clk | input | 1 | External clock pin, asynchronous to `clk` |
| tick | output | 1 | Baud tick, registered |

## Verification
The bench goes after several corner cases:
- **Divisor zero.** A counter that does not reload on zero would tick at 2 cycles instead of 1, or stop ticking altogether.
- **Fastest legal external clock.** An edge detector that merged adjacent edges or counted both edges would halve or double the period.
- **Restart on write.** A late reload would put the first tick after the old count instead of after D+1 cycles.
- **Divide by eight in synchronous mode.** An off-by-one in the phase counter would give 7 or 9 times the period.
- **Idle external pin.** A design that counts levels instead of edges would keep ticking with `ext_clk` held still.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
  typedef enum logic {MODE_ASYNC = 1'b0, MODE_SYNC = 1'b1} mode_e;
endpackage

// File: rtl/bg_src_gate.sv
// Source enable: constant in internal mode, rising-edge pulse of synchronised pin otherwise.
module bg_src_gate
  import baud_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src_sel,
  input  logic pin_in,
  output logic src_en
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  logic rise;
  assign rise   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign src_en = (src_sel == SRC_EXT) ? rise : 1'b1;
endmodule

// File: rtl/bg_divider.sv
// Reloading down-counter; raw_tick marks the enabled event that finds the count at zero.
module bg_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic             src_en,
  output logic             raw_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign raw_tick = src_en && at_zero && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= load_val;
      cnt_q <= load_val;
    end else if (src_en) begin
      cnt_q <= at_zero ? div_q : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bg_oversample.sv
// Output stage: passes every raw tick (8x) or one in OVS (1x), registered.
module bg_oversample
  import baud_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  mode_e mode,
  input  logic  raw_tick,
  output logic  tick
);
  localparam int PW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);

  logic [PW-1:0] ph_q;
  logic          wrap;

  assign wrap = (ph_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      tick <= 1'b0;
    end else if (clear) begin
      ph_q <= '0;
      tick <= 1'b0;
    end else if (mode == MODE_SYNC) begin
      if (raw_tick) ph_q <= wrap ? '0 : ph_q + 1'b1;
      tick <= raw_tick && wrap;
    end else begin
      ph_q <= '0;
      tick <= raw_tick;
    end
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int DIV_W       = 15,
  parameter int OVS         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             src_ext,
  input  logic             mode_sync,
  input  logic             ext_clk,
  output logic             tick
);
  src_e  src_sel;
  mode_e mode;
  logic  src_en;
  logic  raw_tick;

  assign src_sel = src_e'(src_ext);
  assign mode    = mode_e'(mode_sync);

  bg_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pin_in(ext_clk), .src_en(src_en)
  );

  bg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_wr), .load_val(div_wdata),
    .src_en(src_en), .raw_tick(raw_tick)
  );

  bg_oversample #(.OVS(OVS)) u_ovs (
    .clk(clk), .rst_n(rst_n), .clear(div_wr), .mode(mode),
    .raw_tick(raw_tick), .tick(tick)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic div_wr,
  input logic src_ext,
  input logic mode_sync,
  input logic tick,
  input logic src_en
);
  // R5: the cycle after a divisor write carries no tick
  a_r5_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> !tick);

  // R4: every tick follows an enabled source event
  a_r4_tick_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(src_en));

  // R8: an external edge yields a single-cycle enable
  a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && src_en) |=> !(src_ext && src_en));

  // R7: synchronous ticks are one cycle wide
  a_r7_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_sync) |=> !tick);
endmodule

bind baud_gen baud_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .src_ext(src_ext),
  .mode_sync(mode_sync), .tick(tick), .src_en(src_en)
);

// File: tb/baud_gen_tb_top.sv
`timescale 1ns/1ps
module baud_gen_tb_top;
  localparam int DIV_W = 15;
  localparam int NV = 9;
  // columns: divisor, src_ext, mode_sync, ext half period (cycles), expected period
  localparam int VEC [NV][5] = '{
    '{3, 0, 0, 1, 4},  '{10, 0, 0, 1, 11}, '{0, 0, 0, 1, 1},
    '{0, 0, 1, 1, 8},  '{2, 0, 1, 1, 24},  '{4, 1, 0, 1, 10},
    '{0, 1, 0, 1, 2},  '{6, 1, 0, 3, 42},  '{1, 1, 1, 2, 64}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_wr = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic src_ext = 1'b0;
  logic mode_sync = 1'b0;
  logic ext_clk = 1'b0;
  logic tick;

  int errors = 0;
  int checks = 0;
  bit ext_run = 1'b0;
  int ext_half = 1;
  int ecnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk)
    if (ext_run) begin
      if (ecnt + 1 >= ext_half) begin ext_clk <= ~ext_clk; ecnt <= 0; end
      else ecnt <= ecnt + 1;
    end

  baud_gen #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .src_ext(src_ext), .mode_sync(mode_sync), .ext_clk(ext_clk), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_div(input int d);
    @(negedge clk);
    div_wdata = DIV_W'(d);
    div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  // waits for a tick, then returns cycles to the next one
  task automatic measure(output int per);
    int n = 0;
    while (!tick && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    per = 1;
    while (!tick && per < 5000) begin @(negedge clk); per++; end
  endtask

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int per;
    int j;
    int cnt;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1 reset", tick, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      src_ext   = VEC[v][1][0];
      mode_sync = VEC[v][2][0];
      ext_half  = VEC[v][3];
      ext_run   = 1'b1;
      write_div(VEC[v][0]);
      measure(per);
      measure(per);
      if (VEC[v][1] == 1)
        chk(per == VEC[v][4], (VEC[v][4] == 2) ? "R8 ext half freq" : "R4 ext period",
            per, VEC[v][4]);
      else if (VEC[v][2] == 1)
        chk(per == VEC[v][4], "R3 sync period", per, VEC[v][4]);
      else
        chk(per == VEC[v][4], "R2/R6 async period with ext toggling", per, VEC[v][4]);
      if (VEC[v][4] > 1) begin
        @(negedge clk);
        chk(tick == 1'b0, (VEC[v][2] == 1) ? "R7 sync width" : "R2 pulse width", tick, 0);
      end
    end

    // R5: restart on write
    src_ext = 1'b0; mode_sync = 1'b0;
    write_div(9);
    repeat (4) @(negedge clk);
    write_div(3);
    chk(tick == 1'b0, "R5 tick low after write", tick, 0);
    j = 0;
    while (!tick && j < 100) begin @(negedge clk); j++; end
    chk(j == 4, "R5 first tick after restart", j, 4);

    // R4: idle external pin yields no ticks
    ext_run = 1'b0;
    ext_clk = 1'b0;
    src_ext = 1'b1;
    write_div(0);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (tick) cnt++; end
    chk(cnt == 0, "R4 idle ext pin", cnt, 0);

    // R1: reset during activity
    src_ext = 1'b0;
    write_div(0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tick == 1'b0, "R1 reset mid-run", tick, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule